// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt requests and routes each one to the CPU interfaces that should see it. Each CPU interface gets the one request it should service next. Shared sources are level-sensitive lines: their pending state follows the input level, sampled once per clock. Sources below ID 32 are private to each CPU. Each CPU has its own enable and pending bits for them, and software raises them by writing the software-interrupt register. Each CPU output gives a valid flag, the winning ID and that ID's priority. A one-cycle acknowledge from a CPU retires the private request it is being shown.

Software uses a word-addressed register bus. Every access carries the ID of the requesting CPU, so that per-CPU registers can be selected. The global switch is one control bit. Enables are changed through separate set and clear views. Each source has a priority byte, a routing byte (bit c selects CPU c) and a two-bit trigger-mode field. A read-only word reports the number of supported IDs.

Top module: `irq_distributor`

## Requirements
- R1: Control word (word address 0) bit 0 turns routing on. While it is 0, `cpu_valid` is 0 for every CPU. The bit reads back in bit 0 of that word.
- R2: Word address 1 is read-only. Bits 4:0 read NSRC/32-1, and writes to it have no effect.
- R3: Enable words are at word addresses 32+k (set view) and 64+k (clear view), and word k covers IDs 32k..32k+31. A 1 bit in a set-view write enables its ID. A 1 bit in a clear-view write disables it. Zero bits leave the enable unchanged. Reads of either view return the current enable bits.
- R4: Enable word 0 (IDs 0..31) is held separately for each CPU. Reads and writes reach only the copy of the CPU named by `bus_cpu`.
- R5: Routing words at word addresses 512+k hold the routing byte of ID 4k+j in bits 8j+7:8j. A shared ID (32 or above) reaches CPU c only when bit c of its routing byte is 1. A private ID reaches only its own CPU.
- R6: Priority words at word addresses 256+k hold the byte of ID 4k+j in bits 8j+7:8j. Each CPU is shown the eligible ID with the smallest priority value. When values are equal, the smaller ID is shown. An ID is eligible when it is enabled, pending and routed to that CPU.
- R7: A shared ID i is pending exactly when `src_in[i-32]` was high at the previous clock edge. When the input falls, the request disappears without any acknowledge.
- R8: A write to word address 2 with bits 9:0 below 32 makes that ID pending for each CPU c whose bit 16+c is 1. A write with a larger ID has no effect. A private request stays pending until its CPU pulses `cpu_ack` while the request is shown, and that pulse clears it for that CPU only.
- R9: Trigger-mode words at word addresses 768+k store 2 bits per ID, 16 IDs per word, and read back as written. All zeros means level-sensitive.
- R10: When a CPU has nothing to service, its ID output reads 1023, its priority output reads 255 and its valid bit reads 0. This is also the state after reset.
- R11: `bus_rdata` updates on the clock edge that samples `bus_rd`. It keeps its value on cycles without a read. Unmapped words and the software-interrupt word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_cpu | input | CW | ID of the CPU making the access |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | NSRC-32 | Shared level inputs; bit i is ID 32+i |
| cpu_ack | input | NCPU | Per-CPU acknowledge of the shown request |
| cpu_valid | output | NCPU | A request is shown to CPU c |
| cpu_irq_id | output | NCPU*10 | Shown ID, 10 bits per CPU |
| cpu_irq_prio | output | NCPU*8 | Priority of the shown ID, 8 bits per CPU |

## Verification
The properties assume that `bus_cpu` always names an existing CPU. They also assume that a read and a write to the same word are never issued in one cycle. The stimulus draws the CPU ID only from 0..NCPU-1. During the mixed random phase it issues at most one bus operation per cycle. Acknowledges are random, so they sometimes arrive while nothing is shown or while a shared ID is shown. The requirements say both cases are harmless, and the reference model checks that on every clock.

// File: rtl/idist_pkg.sv
`timescale 1ns/1ps
package idist_pkg;
    localparam int AW       = 10;
    localparam int IDW      = 10;
    localparam int PW       = 8;
    localparam int NONE_ID  = 1023;
    localparam int W_CTRL   = 0;
    localparam int W_INFO   = 1;
    localparam int W_SOFT   = 2;
    localparam int W_ENSET  = 32;
    localparam int W_ENCLR  = 64;
    localparam int W_PRIO   = 256;
    localparam int W_ROUTE  = 512;
    localparam int W_MODE   = 768;
endpackage

// File: rtl/idist_regs.sv
`timescale 1ns/1ps
module idist_regs
    import idist_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NSRC = 64,
    parameter int CW   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [CW-1:0]          bus_cpu,
    input  logic [AW-1:0]          bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NSRC-33:0]       src_in,
    input  logic [NCPU-1:0]        cpu_ack,
    input  logic [NCPU-1:0]        sel_valid,
    input  logic [NCPU*IDW-1:0]    sel_id,
    output logic                   dist_on,
    output logic [NCPU*32-1:0]     en_local,
    output logic [NSRC-33:0]       en_shared,
    output logic [NCPU*32-1:0]     pend_local,
    output logic [NSRC-33:0]       pend_shared,
    output logic [NSRC*PW-1:0]     prio_bytes,
    output logic [NSRC*8-1:0]      route_bytes
);
    localparam int NGL   = NSRC - 32;
    localparam int NWORD = NSRC / 32;
    localparam int NPW   = NSRC / 4;
    localparam int NMW   = NSRC / 16;

    typedef struct packed {
        logic                on;
        logic [NCPU*32-1:0]  en_l;
        logic [NGL-1:0]      en_g;
        logic [NCPU*32-1:0]  pend_l;
        logic [NGL-1:0]      pend_g;
        logic [NSRC*PW-1:0]  prio;
        logic [NSRC*8-1:0]   route;
        logic [NSRC*2-1:0]   mode;
        logic [31:0]         rdata;
    } state_t;

    state_t st_q, st_d;

    always_comb begin
        int a;
        int cb;
        int k;
        logic [31:0] rword;
        st_d   = st_q;
        a      = int'(bus_addr);
        cb     = int'(bus_cpu) * 32;
        k      = 0;
        rword  = '0;

        st_d.pend_g = src_in;

        for (int c = 0; c < NCPU; c++) begin
            if (cpu_ack[c] && sel_valid[c] && (sel_id[c*IDW +: IDW] < IDW'(32)))
                st_d.pend_l[c*32 + int'(sel_id[c*IDW +: 5])] = 1'b0;
        end

        if (bus_wr) begin
            if (a == W_CTRL)
                st_d.on = bus_wdata[0];
            if (a == W_SOFT && bus_wdata[9:0] < 10'd32) begin
                for (int c = 0; c < NCPU; c++)
                    if (bus_wdata[16+c])
                        st_d.pend_l[c*32 + int'(bus_wdata[4:0])] = 1'b1;
            end
            if (a >= W_ENSET && a < W_ENSET + NWORD) begin
                k = a - W_ENSET;
                if (k == 0) st_d.en_l[cb +: 32] = st_q.en_l[cb +: 32] | bus_wdata;
                else        st_d.en_g[(k-1)*32 +: 32] = st_q.en_g[(k-1)*32 +: 32] | bus_wdata;
            end
            if (a >= W_ENCLR && a < W_ENCLR + NWORD) begin
                k = a - W_ENCLR;
                if (k == 0) st_d.en_l[cb +: 32] = st_q.en_l[cb +: 32] & ~bus_wdata;
                else        st_d.en_g[(k-1)*32 +: 32] = st_q.en_g[(k-1)*32 +: 32] & ~bus_wdata;
            end
            if (a >= W_PRIO && a < W_PRIO + NPW)
                st_d.prio[(a-W_PRIO)*32 +: 32] = bus_wdata;
            if (a >= W_ROUTE && a < W_ROUTE + NPW)
                st_d.route[(a-W_ROUTE)*32 +: 32] = bus_wdata;
            if (a >= W_MODE && a < W_MODE + NMW)
                st_d.mode[(a-W_MODE)*32 +: 32] = bus_wdata;
        end

        if (a == W_CTRL)
            rword = {31'b0, st_q.on};
        else if (a == W_INFO)
            rword = {27'b0, 5'(NWORD-1)};
        else if ((a >= W_ENSET && a < W_ENSET + NWORD) || (a >= W_ENCLR && a < W_ENCLR + NWORD)) begin
            k = (a >= W_ENCLR) ? a - W_ENCLR : a - W_ENSET;
            rword = (k == 0) ? st_q.en_l[cb +: 32] : st_q.en_g[(k-1)*32 +: 32];
        end
        else if (a >= W_PRIO && a < W_PRIO + NPW)
            rword = st_q.prio[(a-W_PRIO)*32 +: 32];
        else if (a >= W_ROUTE && a < W_ROUTE + NPW)
            rword = st_q.route[(a-W_ROUTE)*32 +: 32];
        else if (a >= W_MODE && a < W_MODE + NMW)
            rword = st_q.mode[(a-W_MODE)*32 +: 32];

        if (bus_rd)
            st_d.rdata = rword;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dist_on     = st_q.on;
    assign en_local    = st_q.en_l;
    assign en_shared   = st_q.en_g;
    assign pend_local  = st_q.pend_l;
    assign pend_shared = st_q.pend_g;
    assign prio_bytes  = st_q.prio;
    assign route_bytes = st_q.route;
    assign bus_rdata   = st_q.rdata;
endmodule

// File: rtl/idist_select.sv
`timescale 1ns/1ps
module idist_select
    import idist_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic               dist_on,
    input  logic [NSRC-1:0]    en_vec,
    input  logic [NSRC-1:0]    pend_vec,
    input  logic [NSRC-1:0]    route_vec,
    input  logic [NSRC*PW-1:0] prio_bytes,
    output logic               pick_valid,
    output logic [IDW-1:0]     pick_id,
    output logic [PW-1:0]      pick_prio
);
    always_comb begin
        pick_valid = 1'b0;
        pick_id    = IDW'(NONE_ID);
        pick_prio  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (dist_on && en_vec[i] && pend_vec[i] && route_vec[i] &&
                (!pick_valid || prio_bytes[i*PW +: PW] < pick_prio)) begin
                pick_valid = 1'b1;
                pick_id    = IDW'(i);
                pick_prio  = prio_bytes[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor
    import idist_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NSRC = 64,
    parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [CW-1:0]          bus_cpu,
    input  logic [AW-1:0]          bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NSRC-33:0]       src_in,
    input  logic [NCPU-1:0]        cpu_ack,
    output logic [NCPU-1:0]        cpu_valid,
    output logic [NCPU*IDW-1:0]    cpu_irq_id,
    output logic [NCPU*PW-1:0]     cpu_irq_prio
);
    logic                 dist_on;
    logic [NCPU*32-1:0]   en_local, pend_local;
    logic [NSRC-33:0]     en_shared, pend_shared;
    logic [NSRC*PW-1:0]   prio_bytes;
    logic [NSRC*8-1:0]    route_bytes;

    idist_regs #(.NCPU(NCPU), .NSRC(NSRC), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .cpu_ack(cpu_ack),
        .sel_valid(cpu_valid), .sel_id(cpu_irq_id),
        .dist_on(dist_on), .en_local(en_local), .en_shared(en_shared),
        .pend_local(pend_local), .pend_shared(pend_shared),
        .prio_bytes(prio_bytes), .route_bytes(route_bytes)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] route_vec;
        for (genvar i = 0; i < NSRC; i++) begin : g_rt
            if (i < 32) begin : g_local
                assign route_vec[i] = 1'b1;
            end else begin : g_shared
                assign route_vec[i] = route_bytes[i*8 + c];
            end
        end
        idist_select #(.NSRC(NSRC)) u_sel (
            .dist_on(dist_on),
            .en_vec({en_shared, en_local[c*32 +: 32]}),
            .pend_vec({pend_shared, pend_local[c*32 +: 32]}),
            .route_vec(route_vec),
            .prio_bytes(prio_bytes),
            .pick_valid(cpu_valid[c]),
            .pick_id(cpu_irq_id[c*IDW +: IDW]),
            .pick_prio(cpu_irq_prio[c*PW +: PW])
        );
    end

    logic unused_route;
    assign unused_route = ^route_bytes;
endmodule

// File: rtl/irq_distributor_chk.sv
`timescale 1ns/1ps
module irq_distributor_chk
    import idist_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NSRC = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [AW-1:0]       bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NCPU-1:0]     cpu_valid,
    input logic [NCPU*IDW-1:0] cpu_irq_id,
    input logic [NCPU*PW-1:0]  cpu_irq_prio
);
    a_r1_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(W_CTRL) && !bus_wdata[0]) |=> (cpu_valid == '0));

    a_r2_info_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'(W_INFO)) |=> (bus_rdata == 32'(NSRC/32 - 1)));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_valid[c] |-> (cpu_irq_id[c*IDW +: IDW] == IDW'(NONE_ID) &&
                               cpu_irq_prio[c*PW +: PW] == '1));
        a_r6_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_valid[c] |-> (cpu_irq_id[c*IDW +: IDW] < IDW'(NSRC)));
    end
endmodule

bind irq_distributor irq_distributor_chk #(.NCPU(NCPU), .NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_valid(cpu_valid), .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio)
);

// File: tb/irq_distributor_bench.sv
`timescale 1ns/1ps
module irq_distributor_bench;
    localparam int NCPU = 2;
    localparam int NSRC = 64;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [0:0]  bus_cpu = 0;
    logic [9:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [NSRC-33:0] src_in = '0;
    logic [NCPU-1:0]  cpu_ack = '0;
    logic [NCPU-1:0]  cpu_valid;
    logic [NCPU*10-1:0] cpu_irq_id;
    logic [NCPU*8-1:0]  cpu_irq_prio;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_distributor #(.NCPU(NCPU), .NSRC(NSRC)) u_irq_distributor (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_in(src_in), .cpu_ack(cpu_ack),
        .cpu_valid(cpu_valid), .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio)
    );

    // ---------------- behavioural reference model ----------------
    bit        m_on = 0;
    bit        m_enl[NCPU][32];
    bit        m_eng[NSRC];
    bit        m_pl[NCPU][32];
    bit        m_src[NSRC];
    int        m_prio[NSRC];
    int        m_route[NSRC];
    int        m_mode[NSRC];
    bit [31:0] m_rd = 0;

    function automatic void m_reset();
        m_on = 0; m_rd = 0;
        for (int i = 0; i < NSRC; i++) begin
            m_eng[i] = 0; m_src[i] = 0; m_prio[i] = 0; m_route[i] = 0; m_mode[i] = 0;
        end
        for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < 32; i++) begin m_enl[c][i] = 0; m_pl[c][i] = 0; end
    endfunction

    function automatic void m_pick(int c, output bit v, output int id, output int p);
        v = 0; id = 1023; p = 255;
        if (!m_on) return;
        for (int i = 0; i < NSRC; i++) begin
            bit en, pd, rt;
            en = (i < 32) ? m_enl[c][i] : m_eng[i];
            pd = (i < 32) ? m_pl[c][i]  : m_src[i];
            rt = (i < 32) ? 1'b1 : 1'(((m_route[i] >> c) & 1));
            if (en && pd && rt && (!v || m_prio[i] < p)) begin
                v = 1; id = i; p = m_prio[i];
            end
        end
    endfunction

    function automatic bit [31:0] m_read(int c, int a);
        bit [31:0] r = 0;
        if (a == 0) r = 32'(m_on);
        else if (a == 1) r = 32'(NSRC/32 - 1);
        else if ((a >= 32 && a < 32 + NSRC/32) || (a >= 64 && a < 64 + NSRC/32)) begin
            int k = (a >= 64) ? a - 64 : a - 32;
            for (int b = 0; b < 32; b++) r[b] = (k == 0) ? m_enl[c][b] : m_eng[k*32 + b];
        end
        else if (a >= 256 && a < 256 + NSRC/4)
            for (int j = 0; j < 4; j++) r[8*j +: 8] = 8'(m_prio[(a-256)*4 + j]);
        else if (a >= 512 && a < 512 + NSRC/4)
            for (int j = 0; j < 4; j++) r[8*j +: 8] = 8'(m_route[(a-512)*4 + j]);
        else if (a >= 768 && a < 768 + NSRC/16)
            for (int j = 0; j < 16; j++) r[2*j +: 2] = 2'(m_mode[(a-768)*16 + j]);
        return r;
    endfunction

    function automatic void m_write(int c, int a, bit [31:0] d);
        if (a == 0) m_on = d[0];
        if (a == 2 && d[9:0] < 32)
            for (int k = 0; k < NCPU; k++) if (d[16+k]) m_pl[k][d[4:0]] = 1;
        if (a >= 32 && a < 32 + NSRC/32)
            for (int b = 0; b < 32; b++) if (d[b]) begin
                if (a == 32) m_enl[c][b] = 1; else m_eng[(a-32)*32 + b] = 1;
            end
        if (a >= 64 && a < 64 + NSRC/32)
            for (int b = 0; b < 32; b++) if (d[b]) begin
                if (a == 64) m_enl[c][b] = 0; else m_eng[(a-64)*32 + b] = 0;
            end
        if (a >= 256 && a < 256 + NSRC/4)
            for (int j = 0; j < 4; j++) m_prio[(a-256)*4 + j] = int'(d[8*j +: 8]);
        if (a >= 512 && a < 512 + NSRC/4)
            for (int j = 0; j < 4; j++) m_route[(a-512)*4 + j] = int'(d[8*j +: 8]);
        if (a >= 768 && a < 768 + NSRC/16)
            for (int j = 0; j < 16; j++) m_mode[(a-768)*16 + j] = int'(d[2*j +: 2]);
    endfunction

    initial m_reset();

    always @(posedge clk) begin : model_step
        bit av[NCPU];
        int aid[NCPU];
        int ap;
        if (!rst_n) m_reset();
        else begin
            for (int c = 0; c < NCPU; c++) m_pick(c, av[c], aid[c], ap);
            if (bus_rd) m_rd = m_read(int'(bus_cpu), int'(bus_addr));
            for (int i = 32; i < NSRC; i++) m_src[i] = src_in[i-32];
            for (int c = 0; c < NCPU; c++)
                if (cpu_ack[c] && av[c] && aid[c] < 32) m_pl[c][aid[c]] = 0;
            if (bus_wr) m_write(int'(bus_cpu), int'(bus_addr), bus_wdata);
        end
    end

    // ---------------- checking ----------------
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin : compare_step
        bit v; int id; int p;
        cycles++;
        if (!done) begin
            for (int c = 0; c < NCPU; c++) begin
                m_pick(c, v, id, p);
                check("R6 valid", 32'(cpu_valid[c]), 32'(v));
                check("R6 id", 32'(cpu_irq_id[c*10 +: 10]), 32'(id));
                check("R6 prio", 32'(cpu_irq_prio[c*8 +: 8]), 32'(p));
            end
            check("R11 rdata", bus_rdata, m_rd);
        end
    end

    function automatic logic [31:0] shown_id(int c);
        return 32'(cpu_irq_id[c*10 +: 10]);
    endfunction

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic wr(int c, int a, logic [31:0] d);
        bus_wr = 1; bus_cpu = 1'(c); bus_addr = 10'(a); bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(int c, int a, output logic [31:0] v);
        bus_rd = 1; bus_cpu = 1'(c); bus_addr = 10'(a);
        tick();
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R10: state after reset
        check("R10 valid", 32'(cpu_valid), 0);
        check("R10 id", shown_id(0), 1023);
        check("R10 prio", 32'(cpu_irq_prio[7:0]), 255);
        rst_n = 1;
        tick();
        rd(0, 0, v); check("R1 ctrl reset", v, 0);
        rd(0, 1, v); check("R2 info", v, 1);
        wr(0, 1, 32'h1F); rd(1, 1, v); check("R2 read-only", v, 1);

        // priorities and routing for shared IDs 32..63
        for (int k = 8; k < 16; k++) begin
            wr(0, 256 + k, 32'hA0A0A0A0);
            wr(0, 512 + k, 32'h01010101);
        end
        wr(0, 256 + 10, 32'h70505060);   // id40=60 id41=50 id42=50 id43=70
        wr(0, 512 + 10, 32'h02020101);   // 40,41 -> cpu0 ; 42,43 -> cpu1
        wr(0, 0, 1);
        rd(1, 0, v); check("R1 ctrl on", v, 1);
        wr(0, 33, 32'h0000_0F00);        // enable 40..43
        rd(1, 65, v); check("R3 clear view reads", v, 32'h0F00);
        src_in[11:8] = 4'hF;
        tick();
        check("R6 cpu0 lower prio", shown_id(0), 41);
        check("R5 cpu1 routed", shown_id(1), 42);
        wr(0, 256 + 10, 32'h70505050);
        check("R6 tie lowest id", shown_id(0), 40);
        wr(0, 65, 32'h0000_0100);        // disable id40 only
        rd(0, 33, v); check("R3 zero bits kept", v, 32'h0E00);
        check("R3 cleared id gone", shown_id(0), 41);
        src_in[9] = 0;
        tick();
        check("R7 level drop", 32'(cpu_valid[0]), 0);

        // banked enables
        wr(1, 32, 32'h20);
        rd(0, 32, v); check("R4 cpu0 copy", v, 0);
        rd(1, 32, v); check("R4 cpu1 copy", v, 32'h20);

        // software interrupt id5 to both CPUs
        wr(0, 2, 32'h0003_0005);
        check("R8 cpu1 shows soft", shown_id(1), 5);
        check("R8 cpu0 not enabled", 32'(cpu_valid[0]), 0);
        wr(0, 2, 32'h0003_0025);        // id 37: ignored
        check("R8 large id ignored", shown_id(1), 5);
        cpu_ack = 2'b10; tick(); cpu_ack = 0;
        check("R8 ack retires", shown_id(1), 42);
        wr(0, 32, 32'h20);
        check("R8 cpu0 still pending", shown_id(0), 5);

        // trigger modes
        wr(0, 770, 32'hAAAA5555);
        rd(1, 770, v); check("R9 mode readback", v, 32'hAAAA5555);

        // global off
        wr(0, 0, 0);
        check("R1 off no valid", 32'(cpu_valid), 0);
        rd(0, 2, v); check("R11 soft word reads 0", v, 0);
        repeat (3) tick();
        check("R11 rdata held", bus_rdata, 0);
        wr(0, 0, 1);

        // mixed random phase, compared every clock against the model
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 16);
            int sel;
            src_in = NSRC'($urandom);
            cpu_ack = 2'($urandom % 4 == 0 ? $urandom : 0);
            bus_cpu = 1'($urandom);
            bus_wr = 0; bus_rd = 0;
            case (int'($urandom % 9))
                0: sel = 0;
                1: sel = 2;
                2: sel = 32 + int'($urandom % 2);
                3: sel = 64 + int'($urandom % 2);
                4: sel = 256 + int'($urandom % 16);
                5: sel = 512 + int'($urandom % 16);
                6: sel = 768 + int'($urandom % 4);
                7: sel = 1;
                default: sel = int'($urandom % 1024);
            endcase
            bus_addr = 10'(sel);
            if (sel == 0)      bus_wdata = 32'($urandom % 5 != 0);
            else if (sel == 2) bus_wdata = {8'h0, 8'($urandom), 6'h0, 10'($urandom % 40)};
            else               bus_wdata = $urandom;
            if (r < 5) bus_wr = 1;
            else if (r < 10) bus_rd = 1;
            tick();
        end
        bus_wr = 0; bus_rd = 0; cpu_ack = 0;
        tick();
        finish_run();
    end
endmodule